// File: doc/BRIEF.md
# Secondary Bus Mode and Clock Range Detector

This block runs once after reset and decides how a PCI-X secondary bus will run. It reads a capability sense line twice. The first read has only the board's weak pull-up in place. If that read is low, the block turns on an external strong pull-up and reads the line again. This tells a hard-grounded line apart from a line held low by a PCI-X 66 device. When the first read is already high, the block reads a frequency select input instead, and that input picks between two clock ranges for a bus whose devices can all run at 133.

The result is a two-bit mode code and a set of clock-path controls. In conventional PCI mode the block asserts a bypass flag, so the bus clock is used directly. In any PCI-X mode it asserts a PLL enable and holds a lock-wait flag for a parameterised number of cycles. Only then does it raise done. Both inputs arrive from pins and pass through two-flop synchronizers. After each change of the pull-up enable, the block waits a parameterised settle time before it samples.

Top module: `busmode_detect`

## Requirements
- R1: While rst_n is low, and after any re-assertion of rst_n, the outputs read done=0, mode=2'b00, strong_pu_en=0, pll_en=0, pll_bypass=0 and lock_wait=0. The strong pull-up enable stays low for the whole first settle window.
- R2: The first sample of the sense line is taken SETTLE_CYCLES clock edges after reset release. If that sample is low, strong_pu_en rises at that edge, and the second sample is taken SETTLE_CYCLES edges later.
- R3: If the second sample is low, then at that same edge the block sets mode=2'b00, pll_bypass=1, pll_en=0, strong_pu_en=0 and done=1.
- R4: If the second sample is high, the block sets mode=2'b01 (PCI-X 66), and strong_pu_en stays asserted from then on.
- R5: If the first sample is high, the block reads the frequency select. A high select gives mode=2'b10 (PCI-X 100) and a low select gives mode=2'b11 (PCI-X 133). In this case strong_pu_en is never asserted.
- R6: In every PCI-X mode, pll_en rises at the deciding edge and pll_bypass stays low. lock_wait is high for exactly LOCK_CYCLES cycles, and done rises when lock_wait falls.
- R7: The sense and select inputs pass through two flip-flops before they are used. A change of the raw line that is first captured at the sampling edge, or at the edge just before it, does not affect that sample.
- R8: Once done is high, mode, done, strong_pu_en, pll_en and pll_bypass hold their values until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; detection starts when it is released |
| cap_sense_i | input | 1 | Raw capability sense line (asynchronous) |
| freq_sel_i | input | 1 | Raw frequency range select (asynchronous), high selects the lower range |
| strong_pu_en_o | output | 1 | Enable for the switched strong pull-up on the sense line |
| mode_o | output | 2 | 00 conventional, 01 PCI-X 66, 10 PCI-X 100, 11 PCI-X 133 |
| pll_bypass_o | output | 1 | Bus clock used directly (conventional mode) |
| pll_en_o | output | 1 | PLL enabled (any PCI-X mode) |
| lock_wait_o | output | 1 | High while the lock interval is running |
| done_o | output | 1 | Decision made and clock ready |

## Verification
A wrong internal state shows up at the ports in one of two ways. It either moves the edge at which done rises, or it changes the mode code or the pull-up enable that goes with it. The bench therefore counts the cycles from reset release to done and compares them with the exact count expected for each path (2·SETTLE, 2·SETTLE+LOCK or SETTLE+LOCK). It also counts how many cycles lock_wait is high. An early sample, a missing synchronizer stage or an off-by-one settle count becomes visible within one settle window. A lost hold after done becomes visible within a cycle of the input noise that the bench applies after the decision.

// File: rtl/busmode_pkg.sv
// Package: shared types for the secondary bus mode detector.
// Assumes: nothing; holds only type definitions.
package busmode_pkg;

    // Mode code seen at the block's output.
    typedef enum logic [1:0] {
        MODE_CONV = 2'b00,
        MODE_X66  = 2'b01,
        MODE_X100 = 2'b10,
        MODE_X133 = 2'b11
    } bus_mode_e;

    // Detection sequence.
    typedef enum logic [1:0] {
        ST_PROBE_WEAK   = 2'b00,
        ST_PROBE_STRONG = 2'b01,
        ST_LOCK         = 2'b10,
        ST_DONE         = 2'b11
    } det_state_e;

endpackage

// File: rtl/bmd_sync.sv
// Module: bmd_sync
// Two-flop synchronizer, one chain per bit.
// Assumes: each bit is an independent level; no multi-bit coherency is implied.
module bmd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1, s2;

        // Capture the raw level, then retime it once more.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_i[b];
                s2 <= s1;
            end
        end

        assign q_o[b] = s2;
    end

endmodule

// File: rtl/bmd_timer.sv
// Module: bmd_timer
// Loadable down counter that stops at zero and flags expiry.
// Assumes: load has priority over counting; reset loads RST_VAL.
module bmd_timer #(
    parameter int          CW      = 8,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;

    // Reload on request, otherwise count down and stay at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RST_VAL;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bmd_fsm.sv
// Module: bmd_fsm
// Sequencer: weak probe, optional strong probe, lock wait, done.
// Assumes: sense_i/fsel_i are already synchronized; timer_zero_i flags the
// end of the interval loaded through timer_load_o.
module bmd_fsm
    import busmode_pkg::*;
#(
    parameter int            CW       = 8,
    parameter logic [CW-1:0] SETTLE_M1 = '0,
    parameter logic [CW-1:0] LOCK_M1   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sense_i,
    input  logic          fsel_i,
    input  logic          timer_zero_i,
    output logic          timer_load_o,
    output logic [CW-1:0] timer_val_o,
    output logic          strong_pu_en_o,
    output bus_mode_e     mode_o,
    output logic          pll_bypass_o,
    output logic          pll_en_o,
    output logic          lock_wait_o,
    output logic          done_o
);

    det_state_e state_q, state_d;
    bus_mode_e  mode_q, mode_d;
    logic       pu_q, pu_d;
    logic       byp_q, byp_d;
    logic       pll_q, pll_d;
    logic       done_q, done_d;

    // Next-state and decision logic.
    always_comb begin
        state_d      = state_q;
        mode_d       = mode_q;
        pu_d         = pu_q;
        byp_d        = byp_q;
        pll_d        = pll_q;
        done_d       = done_q;
        timer_load_o = 1'b0;
        timer_val_o  = SETTLE_M1;
        unique case (state_q)
            ST_PROBE_WEAK: begin
                if (timer_zero_i) begin
                    timer_load_o = 1'b1;
                    if (sense_i) begin
                        mode_d      = fsel_i ? MODE_X100 : MODE_X133;
                        pll_d       = 1'b1;
                        timer_val_o = LOCK_M1;
                        state_d     = ST_LOCK;
                    end else begin
                        pu_d        = 1'b1;
                        timer_val_o = SETTLE_M1;
                        state_d     = ST_PROBE_STRONG;
                    end
                end
            end
            ST_PROBE_STRONG: begin
                if (timer_zero_i) begin
                    if (sense_i) begin
                        mode_d       = MODE_X66;
                        pll_d        = 1'b1;
                        timer_load_o = 1'b1;
                        timer_val_o  = LOCK_M1;
                        state_d      = ST_LOCK;
                    end else begin
                        mode_d  = MODE_CONV;
                        pu_d    = 1'b0;
                        byp_d   = 1'b1;
                        done_d  = 1'b1;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_LOCK: begin
                if (timer_zero_i) begin
                    done_d  = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: state_d = ST_PROBE_WEAK;
        endcase
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PROBE_WEAK;
            mode_q  <= MODE_CONV;
            pu_q    <= 1'b0;
            byp_q   <= 1'b0;
            pll_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            pu_q    <= pu_d;
            byp_q   <= byp_d;
            pll_q   <= pll_d;
            done_q  <= done_d;
        end
    end

    assign strong_pu_en_o = pu_q;
    assign mode_o         = mode_q;
    assign pll_bypass_o   = byp_q;
    assign pll_en_o       = pll_q;
    assign lock_wait_o    = (state_q == ST_LOCK);
    assign done_o         = done_q;

endmodule

// File: rtl/busmode_detect.sv
// Module: busmode_detect (top)
// Decides secondary bus mode and clock range once after reset.
// Assumes: SETTLE_CYCLES >= 3 so the two-flop synchronizer is covered by
// the settle window; LOCK_CYCLES >= 1; reset is synchronous, active low.
module busmode_detect
    import busmode_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16,
    parameter int LOCK_CYCLES   = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_sense_i,
    input  logic       freq_sel_i,
    output logic       strong_pu_en_o,
    output logic [1:0] mode_o,
    output logic       pll_bypass_o,
    output logic       pll_en_o,
    output logic       lock_wait_o,
    output logic       done_o
);

    localparam int MAXC = (SETTLE_CYCLES > LOCK_CYCLES) ? SETTLE_CYCLES : LOCK_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SETTLE_M1 = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0] LOCK_M1   = CW'(LOCK_CYCLES - 1);

    logic [1:0]    raw_in, sync_in;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    bus_mode_e     mode_e;

    assign raw_in = {freq_sel_i, cap_sense_i};

    bmd_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    bmd_timer #(.CW(CW), .RST_VAL(SETTLE_M1)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    bmd_fsm #(.CW(CW), .SETTLE_M1(SETTLE_M1), .LOCK_M1(LOCK_M1)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sense_i        (sync_in[0]),
        .fsel_i         (sync_in[1]),
        .timer_zero_i   (tmr_zero),
        .timer_load_o   (tmr_load),
        .timer_val_o    (tmr_val),
        .strong_pu_en_o (strong_pu_en_o),
        .mode_o         (mode_e),
        .pll_bypass_o   (pll_bypass_o),
        .pll_en_o       (pll_en_o),
        .lock_wait_o    (lock_wait_o),
        .done_o         (done_o)
    );

    assign mode_o = mode_e;

endmodule

// File: rtl/busmode_detect_chk.sv
// Module: busmode_detect_chk
// Port-level properties of the mode detector, bound to the top.
// Assumes: observes only ports; disabled while rst_n is low.
module busmode_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strong_pu_en_o,
    input logic [1:0] mode_o,
    input logic       pll_bypass_o,
    input logic       pll_en_o,
    input logic       lock_wait_o,
    input logic       done_o
);

    // R8: the decision holds once made.
    a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && $stable(mode_o) && $stable(pll_en_o)
                    && $stable(pll_bypass_o) && $stable(strong_pu_en_o)));

    // R3: bypass only with a finished conventional decision.
    a_r3_bypass_conv: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass_o |-> (done_o && mode_o == 2'b00 && !pll_en_o && !strong_pu_en_o));

    // R6: lock wait only with the PLL on and before done.
    a_r6_lock_wait_pll: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wait_o |-> (pll_en_o && !done_o && !pll_bypass_o));

    // R6: in PCI-X modes done follows the end of the lock wait.
    a_r6_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && pll_en_o) |-> $past(lock_wait_o));

    // R4: a finished decision keeps the strong pull-up only for PCI-X 66.
    a_r4_pu_only_x66: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && strong_pu_en_o) |-> (mode_o == 2'b01));

    // R5: no strong pull-up in the 100/133 modes.
    a_r5_no_pu_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en_o && mode_o[1]) |-> !strong_pu_en_o);

endmodule

bind busmode_detect busmode_detect_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .strong_pu_en_o (strong_pu_en_o),
    .mode_o         (mode_o),
    .pll_bypass_o   (pll_bypass_o),
    .pll_en_o       (pll_en_o),
    .lock_wait_o    (lock_wait_o),
    .done_o         (done_o)
);

// File: tb/tb_busmode_detect.sv
`timescale 1ns/1ps
// Bench: directed and seeded-random runs of the bus mode detector.
module tb_busmode_detect;

    localparam int S = 6;
    localparam int L = 40;

    // Bus population scenarios modelled on the sense line.
    localparam int SC_HARD = 0;  // a device grounds the line
    localparam int SC_X66  = 1;  // line follows the strong pull-up
    localparam int SC_FAST = 2;  // line high regardless
    localparam int SC_LATE = 3;  // line rises just before the first sample

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_sense_i, freq_sel_i;
    logic       strong_pu_en_o, pll_bypass_o, pll_en_o, lock_wait_o, done_o;
    logic [1:0] mode_o;

    int   scen = SC_HARD;
    logic fsel_v = 1'b0;
    logic late_v = 1'b0;
    logic noise_en = 1'b0;
    logic noise_s = 1'b0;
    logic noise_f = 1'b0;
    int   checks = 0;
    int   fails = 0;
    int   gcyc = 0;

    always #2.5 clk = ~clk;

    // Electrical model of the sense line for the chosen scenario.
    always_comb begin
        case (scen)
            SC_HARD: cap_sense_i = 1'b0;
            SC_X66:  cap_sense_i = strong_pu_en_o;
            SC_FAST: cap_sense_i = 1'b1;
            default: cap_sense_i = late_v;
        endcase
        if (noise_en) cap_sense_i = noise_s;
        freq_sel_i = noise_en ? noise_f : fsel_v;
    end

    busmode_detect #(.SETTLE_CYCLES(S), .LOCK_CYCLES(L)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cap_sense_i    (cap_sense_i),
        .freq_sel_i     (freq_sel_i),
        .strong_pu_en_o (strong_pu_en_o),
        .mode_o         (mode_o),
        .pll_bypass_o   (pll_bypass_o),
        .pll_en_o       (pll_en_o),
        .lock_wait_o    (lock_wait_o),
        .done_o         (done_o)
    );

    function automatic int exp_mode(int sc, logic fs);
        if (sc == SC_HARD) return 0;
        if (sc == SC_FAST) return fs ? 2 : 3;
        return 1;
    endfunction

    function automatic int exp_done_cyc(int sc);
        if (sc == SC_HARD) return 2 * S;
        if (sc == SC_FAST) return S + L;
        return 2 * S + L;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_reset_state(input string req);
        chk(done_o == 1'b0 && mode_o == 2'b00 && !strong_pu_en_o && !pll_en_o
            && !pll_bypass_o && !lock_wait_o, req,
            {done_o, mode_o, strong_pu_en_o, pll_en_o, pll_bypass_o, lock_wait_o}, 0);
    endtask

    task automatic run_case(input int sc, input logic fs, input int noise_cycles);
        int cyc = 0;
        int lw = 0;
        int pu_early = 0;
        int em = exp_mode(sc, fs);
        logic [1:0] m_hold;
        logic pu_hold;
        logic pll_hold;
        logic byp_hold;
        rst_n = 1'b0;
        noise_en = 1'b0;
        late_v = 1'b0;
        scen = sc;
        fsel_v = fs;
        repeat (3) @(negedge clk);
        check_reset_state("R1 reset outputs");
        rst_n = 1'b1;
        while (!done_o && cyc < 4 * (S + L)) begin
            @(negedge clk);
            cyc++;
            if (sc == SC_LATE && cyc == S - 1) late_v = 1'b1;
            if (cyc < S && strong_pu_en_o) pu_early++;
            if (cyc == S && (sc == SC_HARD || sc == SC_X66 || sc == SC_LATE))
                chk(strong_pu_en_o == 1'b1, "R2 strong pull-up after low sample", strong_pu_en_o, 1);
            if (lock_wait_o) lw++;
        end
        chk(pu_early == 0, "R1 pull-up off in first window", pu_early, 0);
        chk(cyc == exp_done_cyc(sc), "R2 cycles to done", cyc, exp_done_cyc(sc));
        chk(int'(mode_o) == em,
            (sc == SC_LATE) ? "R7 late rise not seen" :
            (sc == SC_FAST) ? "R5 fast mode code" :
            (sc == SC_X66)  ? "R4 x66 mode code" : "R3 conventional mode code",
            mode_o, em);
        if (em == 0) begin
            chk(pll_bypass_o && !pll_en_o && !strong_pu_en_o, "R3 bypass, no pll, no pull-up",
                {pll_bypass_o, pll_en_o, strong_pu_en_o}, 3'b100);
            chk(lw == 0, "R3 no lock wait", lw, 0);
        end else begin
            chk(pll_en_o && !pll_bypass_o, "R6 pll on, no bypass",
                {pll_en_o, pll_bypass_o}, 2'b10);
            chk(lw == L, "R6 lock wait length", lw, L);
            chk(strong_pu_en_o == (em == 1), (em == 1) ? "R4 pull-up kept" : "R5 pull-up off",
                strong_pu_en_o, (em == 1) ? 1 : 0);
        end
        // Post-decision noise must not disturb anything.
        m_hold = mode_o;
        pu_hold = strong_pu_en_o;
        pll_hold = pll_en_o;
        byp_hold = pll_bypass_o;
        noise_en = 1'b1;
        for (int i = 0; i < noise_cycles; i++) begin
            noise_s = 1'($urandom);
            noise_f = 1'($urandom);
            @(negedge clk);
            chk(done_o && mode_o == m_hold && strong_pu_en_o == pu_hold
                && pll_en_o == pll_hold && pll_bypass_o == byp_hold,
                "R8 hold after done", {done_o, mode_o}, {1'b1, m_hold});
        end
        noise_en = 1'b0;
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        // Directed corners.
        run_case(SC_HARD, 1'b0, 4);
        run_case(SC_HARD, 1'b1, 4);
        run_case(SC_X66, 1'b1, 4);
        run_case(SC_FAST, 1'b1, 4);
        run_case(SC_FAST, 1'b0, 4);
        run_case(SC_LATE, 1'b0, 4);
        // Reset mid-sequence restarts detection (R1).
        rst_n = 1'b0;
        scen = SC_FAST;
        fsel_v = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (S + 3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1 reset mid-lock");
        // Seeded random runs.
        for (int r = 0; r < 16; r++) begin
            run_case(int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(2, 10)));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            gcyc++;
            if (gcyc > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", gcyc, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

endmodule